// File: doc/BRIEF.md
# Six-Pin GPIO Port with Snapshot Change Detection

This block is a six-pin general-purpose I/O port for a small 8-bit controller. A simple register bus (address, write data, read data, read and write strobes) reaches four configuration registers and one flag register. Each pin has a direction bit, a weak pull-up enable and a change-detect enable. The block drives an output enable, an output level and a pull-up request to each pad. Pin 3 can only be an input.

Change detection does not compare against the previous clock. It compares each enabled pin against a snapshot of the pins taken at the last access to the data register. While any enabled pin differs from that snapshot, the change flag keeps being set. Software must first access the data register, which refreshes the snapshot. Only then does a clear of the flag take effect. Pin inputs pass through a two-flop synchronizer before they are read, compared or captured.

The register map is: address 0 is data, 1 is direction, 2 is pull-up enables, 3 is change enables, and 4 is the flag (bit 0).

Top module: `gpio_chg_port`

## Requirements
- R1: Address 1 holds one direction bit per pin in bits 5:0. A 1 makes the pin an input, with pad_oe low. A 0 makes it an output, with pad_oe high. After reset every pin is an input.
- R2: Reading address 1 returns 0 in bits 7:6 and 1 in bit 3. pad_oe[3] is never driven high.
- R3: A write to address 0 loads bits 5:0 into the output latch, which drives pad_out. A read of address 0 returns the synchronized pin levels in bits 5:0, with zeros above them.
- R4: At address 2, the pull-up bits 5:4 and 2:0 are writable and reset to 1. Bits 7:6 and bit 3 always read 0.
- R5: pad_pu[i] is high only when all three of these hold: pu_global is high, pull-up bit i is set, and pin i is an input.
- R6: Address 3 holds one change-detect enable per pin in bits 5:0. All of them reset to 0.
- R7: Each pin passes through two flip-flops. A level change on pin_in becomes visible to a data read only after two rising clock edges.
- R8: A pin sets chg_flag at the next clock edge when its change enable is set and its synchronized level differs from the snapshot. A pin whose enable is clear never sets the flag.
- R9: chg_flag is sticky. It stays high until it is cleared, and it is readable as bit 0 of address 4.
- R10: Any read or write of address 0 copies the synchronized pins into the snapshot. After that, writing 0 to bit 0 of address 4 clears chg_flag.
- R11: In a cycle that accesses address 0, a mismatch does not set the flag. A synchronized change that arrives in that same cycle is taken into the snapshot and never raises the flag.
- R12: A clear write to address 4 has no effect in a cycle where a mismatch is present, because setting the flag wins over clearing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (a read of address 0 refreshes the snapshot) |
| rdata | output | 8 | Read data for the selected register |
| pu_global | input | 1 | Global pull-up enable |
| pin_in | input | 6 | Asynchronous pad input levels |
| pad_oe | output | 6 | Per-pin output enable |
| pad_out | output | 6 | Per-pin output level |
| pad_pu | output | 6 | Per-pin weak pull-up request |
| chg_flag | output | 1 | Sticky change flag |

## Verification
Two events can meet in one cycle: a new synchronized pin level can arrive in the same cycle as a data-register access that refreshes the snapshot. The bench changes a pin exactly two edges before a read. It then expects the flag to stay low, because the change is absorbed into the snapshot. It compares this with a read placed one cycle earlier, which must let the flag rise. A second collision is a flag clear issued while a mismatch is still present. The bench expects the flag to remain high in that case, and to clear only after a data access has removed the mismatch.

// File: rtl/gpio_chg_port.sv
module gpio_chg_port #(
  parameter int NPIN = 6,
  parameter int DW = 8,
  parameter int AW = 3,
  parameter logic [NPIN-1:0] INONLY = 6'b001000,
  parameter logic [NPIN-1:0] PU_IMPL = 6'b110111
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic            wr_en,
  input  logic            rd_en,
  output logic [DW-1:0]   rdata,
  input  logic            pu_global,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_pu,
  output logic            chg_flag
);
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_DIR  = AW'(1);
  localparam logic [AW-1:0] A_PU   = AW'(2);
  localparam logic [AW-1:0] A_IOC  = AW'(3);
  localparam logic [AW-1:0] A_FLAG = AW'(4);

  logic [NPIN-1:0] sync1, pin_s, snap, out_q, dir_q, pu_q, ioc_q;
  logic flag_q;
  logic unused_hi;

  wire acc_data = (rd_en || wr_en) && addr == A_DATA;
  wire [NPIN-1:0] dir_eff = dir_q | INONLY;
  wire [NPIN-1:0] mism = (pin_s ^ snap) & ioc_q;
  wire chg_set = |mism && !acc_data;
  wire chg_clr = wr_en && addr == A_FLAG && !wdata[0];

  assign unused_hi = ^wdata[DW-1:NPIN];
  assign pad_oe   = ~dir_eff;
  assign pad_out  = out_q;
  assign pad_pu   = {NPIN{pu_global}} & pu_q & dir_eff;
  assign chg_flag = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      pin_s  <= '0;
      snap   <= '0;
      out_q  <= '0;
      dir_q  <= '1;
      pu_q   <= PU_IMPL;
      ioc_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      sync1 <= pin_in;
      pin_s <= sync1;
      if (acc_data) snap <= pin_s;
      if (wr_en) begin
        case (addr)
          A_DATA:  out_q <= wdata[NPIN-1:0];
          A_DIR:   dir_q <= wdata[NPIN-1:0] | INONLY;
          A_PU:    pu_q  <= wdata[NPIN-1:0] & PU_IMPL;
          A_IOC:   ioc_q <= wdata[NPIN-1:0];
          default: ;
        endcase
      end
      if (chg_set)      flag_q <= 1'b1;
      else if (chg_clr) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_DATA:  rdata[NPIN-1:0] = pin_s;
      A_DIR:   rdata[NPIN-1:0] = dir_eff;
      A_PU:    rdata[NPIN-1:0] = pu_q;
      A_IOC:   rdata[NPIN-1:0] = ioc_q;
      A_FLAG:  rdata[0] = flag_q;
      default: ;
    endcase
  end
endmodule

module gpio_chg_port_chk #(
  parameter int NPIN = 6,
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   wdata,
  input logic            wr_en,
  input logic            rd_en,
  input logic [DW-1:0]   rdata,
  input logic            pu_global,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] pad_pu,
  input logic            chg_flag,
  input logic [NPIN-1:0] pin_s,
  input logic [NPIN-1:0] snap,
  input logic [NPIN-1:0] ioc_q
);
  wire acc  = (rd_en || wr_en) && addr == AW'(0);
  wire clr  = wr_en && addr == AW'(4) && !wdata[0];
  wire mis  = |((pin_s ^ snap) & ioc_q);

  // R5
  pu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_oe) == '0) && (|pad_pu -> pu_global));
  // R2
  dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(1)) |-> (rdata[3] && rdata[DW-1:NPIN] == '0 && !pad_oe[3]));
  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mis && !acc) |=> chg_flag);
  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && !clr) |=> chg_flag);
  // R10
  snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (snap == $past(pin_s)));
  // R11
  acc_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (chg_flag == $past(chg_flag)));
  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mis && clr) |=> chg_flag);
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.NPIN(NPIN), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rd_en(rd_en), .rdata(rdata), .pu_global(pu_global), .pad_oe(pad_oe),
  .pad_pu(pad_pu), .chg_flag(chg_flag), .pin_s(pin_s), .snap(snap),
  .ioc_q(ioc_q)
);

// File: tb/gpio_chg_port_bench.sv
module gpio_chg_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, pu_global = 1'b1;
  logic [7:0] rdata;
  logic [5:0] pin_in = '0, pad_oe, pad_out, pad_pu;
  logic chg_flag;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  gpio_chg_port u_gpio_chg_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .pu_global(pu_global), .pin_in(pin_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .chg_flag(chg_flag)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
    #1;
  endtask

  task automatic set_pins(input logic [5:0] v);
    @(negedge clk); pin_in = v;
  endtask

  task automatic settle;
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(3'd1, d); chk("R1 dir reset", d, 8'h3F);
    chk("R1 oe reset", {2'b0, pad_oe}, 8'h00);
    rd(3'd2, d); chk("R4 pu reset", d, 8'h37);
    rd(3'd3, d); chk("R6 ioc reset", d, 8'h00);
    rd(3'd4, d); chk("R9 flag reset", d, 8'h00);
    chk("R5 pu pads reset", {2'b0, pad_pu}, 8'h37);
  endtask

  task automatic t_dir;
    logic [7:0] d;
    wr(3'd1, 8'h00);
    rd(3'd1, d); chk("R2 dir bit3 forced", d, 8'h08);
    chk("R1 outputs enabled", {2'b0, pad_oe}, 8'h37);
    wr(3'd0, 8'h2A); chk("R3 pad_out", {2'b0, pad_out}, 8'h2A);
    wr(3'd1, 8'hFF);
    rd(3'd1, d); chk("R2 dir upper bits zero", d, 8'h3F);
    chk("R1 all inputs", {2'b0, pad_oe}, 8'h00);
  endtask

  task automatic t_pullup;
    logic [7:0] d;
    wr(3'd2, 8'hFF);
    rd(3'd2, d); chk("R4 pu mask", d, 8'h37);
    wr(3'd1, 8'h30);
    chk("R5 pu only on inputs", {2'b0, pad_pu}, 8'h30);
    chk("R1 mixed oe", {2'b0, pad_oe}, 8'h07);
    @(negedge clk); pu_global = 1'b0; #1;
    chk("R5 global off", {2'b0, pad_pu}, 8'h00);
    @(negedge clk); pu_global = 1'b1;
    wr(3'd1, 8'h3F);
  endtask

  task automatic t_read;
    logic [7:0] d;
    set_pins(6'h15);
    repeat (2) @(negedge clk);
    rd(3'd0, d); chk("R3 read pins", d, 8'h15);
    set_pins(6'h2A);
    rd(3'd0, d); chk("R7 one edge not yet visible", d, 8'h15);
    rd(3'd0, d); chk("R7 visible after two edges", d, 8'h2A);
  endtask

  task automatic t_change;
    logic [7:0] d;
    wr(3'd3, 8'h01);
    rd(3'd3, d); chk("R6 ioc write", d, 8'h01);
    set_pins(6'h2E); settle();
    chk("R8 disabled pin ignored", {7'b0, chg_flag}, 8'h00);
    set_pins(6'h2F); settle();
    chk("R8 enabled pin sets flag", {7'b0, chg_flag}, 8'h01);
    rd(3'd4, d); chk("R9 flag readable", d, 8'h01);
  endtask

  task automatic t_sticky;
    logic [7:0] d;
    wr(3'd4, 8'h00);
    chk("R12 clear ignored under mismatch", {7'b0, chg_flag}, 8'h01);
    repeat (2) @(negedge clk); #1;
    chk("R9 flag sticky", {7'b0, chg_flag}, 8'h01);
    rd(3'd0, d);
    chk("R9 read does not clear", {7'b0, chg_flag}, 8'h01);
    wr(3'd4, 8'h00);
    chk("R10 clear after read", {7'b0, chg_flag}, 8'h00);
    settle();
    chk("R10 stays clear", {7'b0, chg_flag}, 8'h00);
  endtask

  task automatic t_wr_refresh;
    set_pins(6'h2E); settle();
    chk("R8 flag set again", {7'b0, chg_flag}, 8'h01);
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h00);
    chk("R10 clear after data write", {7'b0, chg_flag}, 8'h00);
    settle();
    chk("R10 write refreshed snapshot", {7'b0, chg_flag}, 8'h00);
  endtask

  task automatic t_coincide;
    logic [7:0] d;
    set_pins(6'h2F);
    @(posedge clk); @(posedge clk);
    rd(3'd0, d);
    settle();
    chk("R11 change in read cycle lost", {7'b0, chg_flag}, 8'h00);
    set_pins(6'h2E);
    rd(3'd0, d);
    settle();
    chk("R11 earlier read keeps change", {7'b0, chg_flag}, 8'h01);
  endtask

  initial begin
    #200_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dir();
    t_pullup();
    t_read();
    t_change();
    t_sticky();
    t_wr_refresh();
    t_coincide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule